// File: doc/BRIEF.md
# PWM duty and period datapath

This block is the arithmetic stage between a control filter and a digital PWM timer. It takes the filter output, the filter period, two signed duty trims, a resonant-duty word, an adaptive-offset value and an event-1 value. It forms the final 18-bit duty, period, event-1 and adaptive values. One LSB of every timing value is one 250 ps high-resolution step. A mode input and a duty selector decide how the terms are combined. In resonant operation, the resonant word either scales the filter output or shifts the period. The offset mode adds a fixed bias of 4 steps to several terms.

Results are clamped to the 18-bit range. Every clamp is recorded in a sticky six-bit overflow word. All outputs are loaded together on an update strobe, so the timer always sees one consistent set.

Top module: `pwm_duty_datapath`

## Requirements
- R1: While `rst_n` is low, every value output and `ovf_o` read 0.
- R2: Outputs change only in the clock cycle that follows a cycle with `upd` high. All four values load in that same cycle.
- R3: Unless the multiply path is selected, the duty is `filt_out + adj_a + adj_b`. Both trims are signed 16-bit words.
- R4: When `resonant` is 1 and `duty_sel` is 2, the duty base is `(filt_out * res_word[13:0]) >> FRAC`, with FRAC = 12. Bits 15:14 of `res_word` are ignored. If the scaled product exceeds 2^18-1, it is clamped and `ovf_o[0]` is set.
- R5: When `resonant` is 1 and `duty_sel` is 0 or 1, the period is `filt_prd` plus `res_word` read as a signed 16-bit value. In every other case, the period equals `filt_prd` and `res_word` has no effect on it.
- R6: When `mode` is 3, the duty, event-1 and adaptive outputs each gain +4. In any other mode, event-1 and adaptive pass through unchanged.
- R7: A duty or period sum below zero gives 0. It sets `ovf_o[1]` for the duty and `ovf_o[3]` for the period.
- R8: A sum above 2^18-1 gives 2^18-1. It sets `ovf_o[2]` for the duty and `ovf_o[4]` for the period. For event-1 or adaptive, it sets `ovf_o[5]`.
- R9: Overflow bits stay set until `clr_ovf` is high for one cycle. If `clr_ovf` and `upd` are both high in the same cycle, the old flags are cleared and the new update's overflows are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | Load strobe for all outputs |
| clr_ovf | input | 1 | Clears the sticky overflow flags |
| mode | input | 2 | Operating mode; 3 selects the +4 offset |
| resonant | input | 1 | Resonant operation enable |
| duty_sel | input | 2 | Duty source selector |
| filt_out | input | 18 | Filter output |
| filt_prd | input | 18 | Filter period |
| adj_a | input | 16 | Signed duty trim A |
| adj_b | input | 16 | Signed duty trim B |
| res_word | input | 16 | Resonant scale or period offset |
| adapt_in | input | 18 | Adaptive offset |
| ev1_in | input | 18 | Event-1 value |
| duty_o | output | 18 | Final duty |
| prd_o | output | 18 | Final period |
| ev1_o | output | 18 | Final event-1 |
| adapt_o | output | 18 | Final adaptive offset |
| ovf_o | output | 6 | Sticky overflow flags |

## Verification
The flag clear and the flag set can land in the same cycle. This happens when `clr_ovf` is raised with an `upd` whose inputs saturate. The bench provokes this both at random and with a directed case in which a fresh high clamp coincides with the clear. It then checks that only the new update's bits remain. A second overlap is the multiply clamp together with a negative trim. Here the product saturates first and the trim then pulls the sum back into range, so `ovf_o[0]` must be set while the duty stays unclamped.

// File: rtl/pwm_duty_datapath.sv
module pwm_duty_datapath #(
  parameter int W    = 18,
  parameter int AW   = 16,
  parameter int RW   = 14,
  parameter int FRAC = 12,
  parameter int OFS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          clr_ovf,
  input  logic [1:0]    mode,
  input  logic          resonant,
  input  logic [1:0]    duty_sel,
  input  logic [W-1:0]  filt_out,
  input  logic [W-1:0]  filt_prd,
  input  logic [AW-1:0] adj_a,
  input  logic [AW-1:0] adj_b,
  input  logic [AW-1:0] res_word,
  input  logic [W-1:0]  adapt_in,
  input  logic [W-1:0]  ev1_in,
  output logic [W-1:0]  duty_o,
  output logic [W-1:0]  prd_o,
  output logic [W-1:0]  ev1_o,
  output logic [W-1:0]  adapt_o,
  output logic [5:0]    ovf_o
);
  localparam int SW = W + 3;
  localparam int PW = W + RW;
  localparam int QW = PW - FRAC;
  localparam logic [W-1:0] MAX = '1;

  logic mul_sel, prd_sel, ofs_on;
  assign mul_sel = resonant && (duty_sel == 2'd2);
  assign prd_sel = resonant && (duty_sel < 2'd2);
  assign ofs_on  = (mode == 2'd3);

  logic [PW-1:0] prod;
  logic [QW-1:0] scaled;
  logic          prod_hi;
  logic [W-1:0]  base;
  assign prod    = filt_out * res_word[RW-1:0];
  assign scaled  = prod[PW-1:FRAC];
  assign prod_hi = mul_sel && (|scaled[QW-1:W]);
  assign base    = !mul_sel ? filt_out : (prod_hi ? MAX : scaled[W-1:0]);

  logic signed [SW-1:0] off_s, duty_s, prd_s;
  assign off_s  = ofs_on ? SW'(OFS) : '0;
  assign duty_s = $signed({3'b000, base})
                + $signed({{(SW-AW){adj_a[AW-1]}}, adj_a})
                + $signed({{(SW-AW){adj_b[AW-1]}}, adj_b})
                + off_s;
  assign prd_s  = $signed({3'b000, filt_prd})
                + (prd_sel ? $signed({{(SW-AW){res_word[AW-1]}}, res_word}) : '0);

  logic duty_lo, duty_hi, prd_lo, prd_hi;
  assign duty_lo = duty_s[SW-1];
  assign duty_hi = !duty_s[SW-1] && (|duty_s[SW-2:W]);
  assign prd_lo  = prd_s[SW-1];
  assign prd_hi  = !prd_s[SW-1] && (|prd_s[SW-2:W]);

  logic [W:0] ev_s, ad_s;
  assign ev_s = {1'b0, ev1_in}   + (ofs_on ? (W+1)'(OFS) : '0);
  assign ad_s = {1'b0, adapt_in} + (ofs_on ? (W+1)'(OFS) : '0);

  logic [W-1:0] duty_n, prd_n;
  assign duty_n = duty_lo ? '0 : (duty_hi ? MAX : duty_s[W-1:0]);
  assign prd_n  = prd_lo  ? '0 : (prd_hi  ? MAX : prd_s[W-1:0]);

  logic [5:0] ovf_n;
  assign ovf_n = {ev_s[W] | ad_s[W], prd_hi, prd_lo, duty_hi, duty_lo, prod_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_o  <= '0;
      prd_o   <= '0;
      ev1_o   <= '0;
      adapt_o <= '0;
      ovf_o   <= '0;
    end else begin
      if (upd) begin
        duty_o  <= duty_n;
        prd_o   <= prd_n;
        ev1_o   <= ev_s[W] ? MAX : ev_s[W-1:0];
        adapt_o <= ad_s[W] ? MAX : ad_s[W-1:0];
      end
      ovf_o <= (clr_ovf ? 6'd0 : ovf_o) | (upd ? ovf_n : 6'd0);
    end
  end
endmodule

// File: rtl/pwm_duty_datapath_chk.sv
module pwm_duty_datapath_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd,
  input logic         clr_ovf,
  input logic [1:0]   mode,
  input logic         resonant,
  input logic [W-1:0] filt_prd,
  input logic [W-1:0] adapt_in,
  input logic [W-1:0] duty_o,
  input logic [W-1:0] prd_o,
  input logic [W-1:0] ev1_o,
  input logic [W-1:0] adapt_o,
  input logic [5:0]   ovf_o
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (duty_o == '0 && prd_o == '0 && ovf_o == '0);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(duty_o) && $stable(prd_o) && $stable(ev1_o) && $stable(adapt_o)));

  assert_prd_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !resonant) |=> prd_o == $past(filt_prd));

  assert_adapt_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == 2'd3 && adapt_in < {W{1'b1}} - W'(4)) |=> adapt_o == $past(adapt_in) + W'(4));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ovf |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !upd) |=> ovf_o == 6'd0);
endmodule

bind pwm_duty_datapath pwm_duty_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .clr_ovf(clr_ovf), .mode(mode),
  .resonant(resonant), .filt_prd(filt_prd), .adapt_in(adapt_in),
  .duty_o(duty_o), .prd_o(prd_o), .ev1_o(ev1_o), .adapt_o(adapt_o), .ovf_o(ovf_o)
);

// File: tb/sim_pwm_duty_datapath.sv
`timescale 1ns/1ps
module sim_pwm_duty_datapath;
  localparam longint MAXV = 262143;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0, clr_ovf = 1'b0, resonant = 1'b0;
  logic [1:0] mode = '0, duty_sel = '0;
  logic [17:0] filt_out = '0, filt_prd = '0, adapt_in = '0, ev1_in = '0;
  logic [15:0] adj_a = '0, adj_b = '0, res_word = '0;
  logic [17:0] duty_o, prd_o, ev1_o, adapt_o;
  logic [5:0] ovf_o;

  int n_chk = 0, n_fail = 0;
  longint e_duty = 0, e_prd = 0, e_ev = 0, e_ad = 0;
  logic [5:0] e_ovf = '0;

  always #4 clk = ~clk;

  pwm_duty_datapath u0 (
    .clk(clk), .rst_n(rst_n), .upd(upd), .clr_ovf(clr_ovf), .mode(mode),
    .resonant(resonant), .duty_sel(duty_sel), .filt_out(filt_out), .filt_prd(filt_prd),
    .adj_a(adj_a), .adj_b(adj_b), .res_word(res_word), .adapt_in(adapt_in),
    .ev1_in(ev1_in), .duty_o(duty_o), .prd_o(prd_o), .ev1_o(ev1_o),
    .adapt_o(adapt_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model(output longint d, output longint p, output longint ev,
                       output longint ad, output logic [5:0] nf);
    longint base, prod, ofs, ds, ps;
    nf = '0;
    ofs = (mode == 2'd3) ? 4 : 0;
    base = filt_out;
    if (resonant && duty_sel == 2'd2) begin
      prod = (longint'(filt_out) * longint'(res_word[13:0])) >>> 12;
      if (prod > MAXV) begin base = MAXV; nf[0] = 1'b1; end
      else base = prod;
    end
    ds = base + sx16(adj_a) + sx16(adj_b) + ofs;
    ps = filt_prd;
    if (resonant && duty_sel < 2'd2) ps = ps + sx16(res_word);
    if (ds < 0) begin d = 0; nf[1] = 1'b1; end
    else if (ds > MAXV) begin d = MAXV; nf[2] = 1'b1; end
    else d = ds;
    if (ps < 0) begin p = 0; nf[3] = 1'b1; end
    else if (ps > MAXV) begin p = MAXV; nf[4] = 1'b1; end
    else p = ps;
    ev = longint'(ev1_in) + ofs;
    ad = longint'(adapt_in) + ofs;
    if (ev > MAXV) begin ev = MAXV; nf[5] = 1'b1; end
    if (ad > MAXV) begin ad = MAXV; nf[5] = 1'b1; end
  endtask

  task automatic apply(input logic clr, input string req);
    logic [5:0] nf;
    @(negedge clk);
    model(e_duty, e_prd, e_ev, e_ad, nf);
    e_ovf = (clr ? 6'd0 : e_ovf) | nf;
    upd = 1'b1; clr_ovf = clr;
    @(negedge clk);
    upd = 1'b0; clr_ovf = 1'b0;
    check({req, " duty"}, duty_o, e_duty);
    check({req, " period"}, prd_o, e_prd);
    check({req, " event1"}, ev1_o, e_ev);
    check({req, " adaptive"}, adapt_o, e_ad);
    check({req, " flags"}, ovf_o, e_ovf);
  endtask

  task automatic set_in(input logic [1:0] m, input logic r, input logic [1:0] s,
                        input logic [17:0] fo, input logic [17:0] fp,
                        input logic [15:0] a, input logic [15:0] b, input logic [15:0] rw,
                        input logic [17:0] adp, input logic [17:0] e1);
    mode = m; resonant = r; duty_sel = s; filt_out = fo; filt_prd = fp;
    adj_a = a; adj_b = b; res_word = rw; adapt_in = adp; ev1_in = e1;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    e_ovf = '0;
    check("R9 clear", ovf_o, 0);
  endtask

  initial begin
    #5000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 duty", duty_o, 0);
    check("R1 period", prd_o, 0);
    check("R1 flags", ovf_o, 0);
    rst_n = 1'b1;

    set_in(2'd0, 1'b0, 2'd0, 18'd1000, 18'd5000, 16'd20, 16'hFFF6, 16'h7FFF, 18'd7, 18'd9);
    apply(1'b0, "R3 R5");
    set_in(2'd1, 1'b1, 2'd2, 18'd100000, 18'd5000, 16'd0, 16'd0, 16'hC800, 18'd7, 18'd9);
    apply(1'b0, "R4");
    set_in(2'd1, 1'b1, 2'd0, 18'd100, 18'd5000, 16'd0, 16'd0, 16'hFF00, 18'd7, 18'd9);
    apply(1'b0, "R5");
    set_in(2'd3, 1'b0, 2'd0, 18'd100, 18'd500, 16'd0, 16'd0, 16'd0, 18'd262140, 18'd262141);
    apply(1'b0, "R6 R8");
    clear_flags();
    set_in(2'd0, 1'b1, 2'd1, 18'd5, 18'd10, 16'h8000, 16'd0, 16'h8000, 18'd0, 18'd0);
    apply(1'b0, "R7");
    set_in(2'd0, 1'b1, 2'd2, 18'd262143, 18'd10, 16'h8000, 16'h8000, 16'h3FFF, 18'd0, 18'd0);
    apply(1'b0, "R4 product clamp");
    set_in(2'd0, 1'b0, 2'd0, 18'd262100, 18'd10, 16'h7FFF, 16'd0, 16'd0, 18'd0, 18'd0);
    apply(1'b1, "R9 clear with update");
    clear_flags();

    set_in(2'd2, 1'b1, 2'd1, 18'd1, 18'd2, 16'd3, 16'd4, 16'd5, 18'd6, 18'd7);
    repeat (3) @(negedge clk);
    check("R2 hold duty", duty_o, e_duty);
    check("R2 hold period", prd_o, e_prd);
    check("R2 hold flags", ovf_o, e_ovf);

    for (int i = 0; i < 400; i++) begin
      set_in(2'($urandom), 1'($urandom), 2'($urandom), 18'($urandom), 18'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom), 18'($urandom), 18'($urandom));
      if ($urandom % 4 == 0) adapt_in = 18'd262140 + 18'($urandom % 4);
      apply(($urandom % 4) == 0, "R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule